// File: doc/BRIEF.md
# Chip-Select-Driven Channel Sequencer

This block is the digital control front end of an eight-input sampling converter. A control word holds a channel-enable mask and a temperature-enable bit. Together they choose which inputs take part in a conversion sequence. Each falling edge of the active-low chip select moves the sequence one step and starts one conversion on the channel that was picked.

In the same cycle, the block also puts the result of the conversion started at the previous edge on its output. This gives exactly one frame of pipeline latency. Each output word carries the channel index of the data it holds, so a host can realign results with their channels.

The converter core sits outside the block and talks to it through a start pulse and a done/data handshake. The analog multiplexer and the serial shift register are not part of this block.

Top module: `chseq_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, all outputs are zero: `conv_start`, `conv_chan`, `conv_temp`, `out_valid`, `out_chan`, `out_temp` and `out_data`.
- R2: A falling edge of `cs_n` is `cs_n` sampled high at one rising clock edge and low at the next. It raises `conv_start` for exactly one cycle, starting just after the edge that first sees the low level, provided the selection is not empty. No other cycle raises `conv_start`.
- R3: Each selected slot is visited once per pass, in ascending order. Slots 0 to 7 are `cfg_mask` bits 0 to 7, and slot 8 is the temperature sensor, enabled by `cfg_temp_en`. After the highest selected slot, the sequence wraps to the lowest. A temperature conversion drives `conv_temp`=1 and `conv_chan`=0.
- R4: A write (`cfg_we`=1) replaces the selection. The next falling edge starts the lowest selected slot, whatever the earlier position was.
- R5: With an empty selection (mask 0 and `cfg_temp_en` 0), a falling edge starts no conversion. The following falling edge then presents `out_valid`=0. Whenever `out_valid` is 0, `out_data`, `out_chan` and `out_temp` are 0.
- R6: At each falling edge the outputs take the result of the conversion started at the previous falling edge. `out_chan` is that conversion's channel index and `out_data` is the `conv_data` word that was accepted for it.
- R7: The result is accepted only if `conv_done` was seen while that conversion was outstanding. If no such done arrives before the next falling edge, that edge presents `out_valid`=0. A `conv_done` pulse with no conversion outstanding has no effect.
- R8: A temperature result is presented with `out_temp`=1, which marks `out_data` as two's complement, and `out_chan`=0. A channel result is presented with `out_temp`=0, which marks straight binary (1 LSB = reference/4096). The data bits are passed through unchanged in both cases.
- R9: The outputs change only at the clock edge that sees a `cs_n` falling edge. Between falling edges, including across the rising edge of `cs_n`, they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select, synchronous to `clk` |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_mask | input | NUM_CH | Channel-enable mask, bit i enables channel i |
| cfg_temp_en | input | 1 | Adds the temperature slot after the highest channel |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| conv_chan | output | $clog2(NUM_CH) | Channel of the conversion being started (0 for temperature) |
| conv_temp | output | 1 | Conversion being started is the temperature sensor |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | DATA_W | Converter result word |
| out_valid | output | 1 | Output word holds an accepted result |
| out_chan | output | $clog2(NUM_CH) | Channel index of `out_data` |
| out_temp | output | 1 | `out_data` is a two's complement temperature code |
| out_data | output | DATA_W | Result of the previous frame's conversion |

## Verification
On every cycle the assertions check the local timing rules. A start appears only right after a sampled falling edge, lasts one cycle, and never occurs with an empty selection. Outputs hold between edges, invalid words are all zero, and temperature words carry channel 0. Only the bench scenarios can show the things that span several frames: the visiting order and its wrap, the restart after a mask write, and the pairing of each output with the conversion from one frame earlier. The same holds for dropping a result whose done never came and ignoring a stray done. The bench covers these with several mask patterns, the temperature slot, an empty mask and a missing completion.

// File: rtl/chseq_pkg.sv
package chseq_pkg;

  // number of sequence slots: every analog channel plus the temperature slot
  function automatic int slot_count(int num_ch);
    return num_ch + 1;
  endfunction

  // output coding of a presented result
  typedef enum logic {
    CODE_STRAIGHT = 1'b0,
    CODE_TWOS     = 1'b1
  } code_e;

endpackage

// File: rtl/chseq_csedge.sv
// Falling-edge detector for the synchronous chip select.
module chseq_csedge (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  output logic fall
);

  logic cs_q;

  // cs_q follows cs_n even in reset so that a level held low across reset
  // release is not mistaken for an edge
  always_ff @(posedge clk) begin
    cs_q <= cs_n;
  end

  assign fall = cs_q & ~cs_n & ~rst;

endmodule

// File: rtl/chseq_cfg.sv
// Control word: selection vector and restart flag.
module chseq_cfg #(
  parameter int NUM_CH = 8,
  parameter int NSLOT  = NUM_CH + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [NUM_CH-1:0] mask_in,
  input  logic             temp_in,
  input  logic             fall,
  output logic [NSLOT-1:0] sel,
  output logic             restart
);

  logic [NUM_CH-1:0] mask_q;
  logic              temp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      temp_q  <= 1'b0;
      restart <= 1'b1;
    end else begin
      if (we) begin
        mask_q  <= mask_in;
        temp_q  <= temp_in;
        restart <= 1'b1;
      end else if (fall) begin
        restart <= 1'b0;
      end
    end
  end

  assign sel = {temp_q, mask_q};

endmodule

// File: rtl/chseq_pick.sv
// Next-slot picker: lowest selected slot above the last one, else the lowest.
module chseq_pick #(
  parameter int NSLOT = 9,
  parameter int SL_W  = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0] sel,
  input  logic [SL_W-1:0]  last,
  input  logic             restart,
  output logic             any,
  output logic [SL_W-1:0]  nxt
);

  logic [NSLOT-1:0] above;
  logic [NSLOT-1:0] src;

  for (genvar g = 0; g < NSLOT; g++) begin : g_above
    localparam logic [SL_W-1:0] GI = SL_W'(g);
    assign above[g] = sel[g] && (GI > last);
  end

  assign src = (restart || (above == '0)) ? sel : above;
  assign any = (sel != '0);

  always_comb begin
    nxt = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (src[i]) nxt = SL_W'(i);
    end
  end

endmodule

// File: rtl/chseq_result.sv
// One-frame result pipeline: capture on done, present on the next falling edge.
module chseq_result #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12,
  parameter int SL_W   = 4,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              start_now,
  input  logic [SL_W-1:0]   slot_now,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic              out_temp,
  output logic [DATA_W-1:0] out_data
);
  import chseq_pkg::*;

  localparam logic [SL_W-1:0] TEMP_SLOT = SL_W'(NUM_CH);

  logic              busy;
  logic              res_ok;
  logic [DATA_W-1:0] res_data;
  logic              p_started;
  logic [SL_W-1:0]   p_slot;
  logic              present;
  code_e             p_code;

  assign present = p_started & res_ok;
  assign p_code  = (p_slot == TEMP_SLOT) ? CODE_TWOS : CODE_STRAIGHT;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      res_ok    <= 1'b0;
      res_data  <= '0;
      p_started <= 1'b0;
      p_slot    <= '0;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_temp  <= 1'b0;
      out_data  <= '0;
    end else begin
      if (conv_done && busy) begin
        res_data <= conv_data;
        res_ok   <= 1'b1;
        busy     <= 1'b0;
      end
      if (fall) begin
        out_valid <= present;
        out_data  <= present ? res_data : '0;
        out_temp  <= present && (p_code == CODE_TWOS);
        out_chan  <= (present && (p_code == CODE_STRAIGHT)) ? p_slot[CH_W-1:0] : '0;
        res_ok    <= 1'b0;
        busy      <= start_now;
        p_started <= start_now;
        p_slot    <= slot_now;
      end
    end
  end

endmodule

// File: rtl/chseq_top.sv
// Chip-select-driven channel sequencer, top level.
module chseq_top #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       cfg_we,
  input  logic [NUM_CH-1:0]          cfg_mask,
  input  logic                       cfg_temp_en,
  output logic                       conv_start,
  output logic [$clog2(NUM_CH)-1:0]  conv_chan,
  output logic                       conv_temp,
  input  logic                       conv_done,
  input  logic [DATA_W-1:0]          conv_data,
  output logic                       out_valid,
  output logic [$clog2(NUM_CH)-1:0]  out_chan,
  output logic                       out_temp,
  output logic [DATA_W-1:0]          out_data
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int NSLOT = chseq_pkg::slot_count(NUM_CH);
  localparam int SL_W  = $clog2(NSLOT);
  localparam logic [SL_W-1:0] TEMP_SLOT = SL_W'(NUM_CH);

  logic             fall;
  logic [NSLOT-1:0] sel;
  logic             restart;
  logic             any;
  logic [SL_W-1:0]  nxt;
  logic [SL_W-1:0]  last;

  chseq_csedge u_edge (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .fall (fall)
  );

  chseq_cfg #(.NUM_CH(NUM_CH), .NSLOT(NSLOT)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .mask_in (cfg_mask),
    .temp_in (cfg_temp_en),
    .fall    (fall),
    .sel     (sel),
    .restart (restart)
  );

  chseq_pick #(.NSLOT(NSLOT), .SL_W(SL_W)) u_pick (
    .sel     (sel),
    .last    (last),
    .restart (restart),
    .any     (any),
    .nxt     (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      conv_chan  <= '0;
      conv_temp  <= 1'b0;
      last       <= '0;
    end else begin
      conv_start <= fall && any;
      if (fall && any) begin
        conv_chan <= (nxt == TEMP_SLOT) ? '0 : nxt[CH_W-1:0];
        conv_temp <= (nxt == TEMP_SLOT);
        last      <= nxt;
      end
    end
  end

  chseq_result #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .SL_W   (SL_W),
    .CH_W   (CH_W)
  ) u_res (
    .clk       (clk),
    .rst       (rst),
    .fall      (fall),
    .start_now (any),
    .slot_now  (nxt),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_temp  (out_temp),
    .out_data  (out_data)
  );

endmodule

// File: rtl/chseq_checker.sv
// Cycle-level properties of the sequencer, bound to the top module.
module chseq_checker #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cs_n,
  input logic [NUM_CH:0]           sel,
  input logic                      conv_start,
  input logic [$clog2(NUM_CH)-1:0] conv_chan,
  input logic                      conv_temp,
  input logic                      out_valid,
  input logic [$clog2(NUM_CH)-1:0] out_chan,
  input logic                      out_temp,
  input logic [DATA_W-1:0]         out_data
);

  AST_START_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (!$past(cs_n) && $past(cs_n, 2))); // R2

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R2

  AST_START_EACH_FALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cs_n) && $past(cs_n, 2) && ($past(sel) != '0)) |-> conv_start); // R2

  AST_NO_START_EMPTY: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ($past(sel) != '0)); // R5

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0 && out_chan == '0 && !out_temp)); // R5

  AST_TEMP_CONV_CHAN: assert property (@(posedge clk) disable iff (rst)
    conv_temp |-> (conv_chan == '0)); // R3

  AST_TEMP_OUT_CHAN: assert property (@(posedge clk) disable iff (rst)
    out_temp |-> (out_chan == '0 && out_valid)); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(!$past(cs_n) && $past(cs_n, 2)) |->
      ($stable(out_valid) && $stable(out_chan) && $stable(out_temp) && $stable(out_data))); // R9

endmodule

bind chseq_top chseq_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .sel        (sel),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .conv_temp  (conv_temp),
  .out_valid  (out_valid),
  .out_chan   (out_chan),
  .out_temp   (out_temp),
  .out_data   (out_data)
);

// File: tb/tb_chseq_top.sv
module tb_chseq_top;
  localparam int NUM_CH = 8;
  localparam int DATA_W = 12;
  localparam int TSLOT  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_mask = '0;
  logic        cfg_temp_en = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        conv_start, conv_temp, out_valid, out_temp;
  logic [2:0]  conv_chan, out_chan;
  logic [11:0] out_data;

  chseq_top #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
    .cfg_temp_en(cfg_temp_en), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_temp(conv_temp), .conv_done(conv_done), .conv_data(conv_data),
    .out_valid(out_valid), .out_chan(out_chan), .out_temp(out_temp), .out_data(out_data)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int  cd = 0;
  int  seq_n = 0;
  bit  drop_next = 0;
  bit  drop_cur = 0;
  bit  stray_req = 0;
  int  cur_slot = 0;

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (stray_req) begin
      conv_done = 1'b1;
      conv_data = 12'hABC;
      stray_req = 0;
    end else if (conv_start) begin
      cd = 3;
      cur_slot = conv_temp ? TSLOT : int'(conv_chan);
      drop_cur = drop_next;
      drop_next = 0;
      seq_n++;
    end else if (cd > 0) begin
      cd--;
      if (cd == 0 && !drop_cur) begin
        conv_done = 1'b1;
        conv_data = (cur_slot == TSLOT) ? (12'hE00 | 12'(seq_n & 8'hFF))
                                        : {3'(cur_slot), 9'(seq_n)};
      end
    end
  end

  // ---------------- reference model ----------------
  bit m_csq = 1;
  bit [7:0] m_mask = 0;
  bit m_ten = 0, m_restart = 1, m_busy = 0, m_resok = 0, m_pst = 0;
  int m_last = 0, m_pslot = 0, m_res = 0;
  bit e_start = 0, e_ctemp = 0, e_valid = 0, e_temp = 0;
  int e_cchan = 0, e_chan = 0, e_data = 0;

  function automatic bit m_en(int i);
    return (i < 8) ? m_mask[i] : m_ten;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mask = 0; m_ten = 0; m_restart = 1; m_busy = 0; m_resok = 0; m_pst = 0;
      m_last = 0; m_pslot = 0; m_res = 0;
      e_start = 0; e_ctemp = 0; e_valid = 0; e_temp = 0; e_cchan = 0; e_chan = 0; e_data = 0;
    end else begin
      bit fell;
      int nx;
      fell = m_csq && !cs_n;
      e_start = 0;
      if (fell) begin
        bit pres;
        pres = m_pst && m_resok;
        e_valid = pres;
        e_data  = pres ? m_res : 0;
        e_temp  = pres && (m_pslot == TSLOT);
        e_chan  = (pres && m_pslot != TSLOT) ? m_pslot : 0;
        m_resok = 0;
        nx = -1;
        if (!m_restart)
          for (int i = m_last + 1; i <= TSLOT; i++) if (nx < 0 && m_en(i)) nx = i;
        if (nx < 0)
          for (int i = 0; i <= TSLOT; i++) if (nx < 0 && m_en(i)) nx = i;
        m_restart = 0;
        if (nx >= 0) begin
          e_start = 1;
          e_ctemp = (nx == TSLOT);
          e_cchan = (nx == TSLOT) ? 0 : nx;
          m_last  = nx;
        end
        m_busy  = (nx >= 0);
        m_pst   = (nx >= 0);
        m_pslot = (nx >= 0) ? nx : 0;
      end else if (conv_done && m_busy) begin
        m_res = int'(conv_data);
        m_resok = 1;
        m_busy = 0;
      end
      if (cfg_we) begin
        m_mask = cfg_mask;
        m_ten = cfg_temp_en;
        m_restart = 1;
      end
    end
    m_csq = cs_n;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(conv_start == e_start, "R2", "conv_start", conv_start, e_start);
      chk(int'(conv_chan) == e_cchan, "R3", "conv_chan", conv_chan, e_cchan);
      chk(conv_temp == e_ctemp, "R3", "conv_temp", conv_temp, e_ctemp);
      chk(out_valid == e_valid, "R6", "out_valid", out_valid, e_valid);
      chk(int'(out_chan) == e_chan, "R6", "out_chan", out_chan, e_chan);
      chk(int'(out_data) == e_data, "R6", "out_data", out_data, e_data);
      chk(out_temp == e_temp, "R8", "out_temp", out_temp, e_temp);
    end
  end

  // ---------------- scenario helpers ----------------
  int starts[$];
  int ovalid[$];
  int ochan[$];
  int otemp[$];
  int odata[$];

  task automatic write_cfg(logic [7:0] m, logic t);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mask = m; cfg_temp_en = t;
    @(negedge clk);
    cfg_we = 1'b0;
    starts.delete(); ovalid.delete(); ochan.delete(); otemp.delete(); odata.delete();
  endtask

  task automatic frame();
    logic [11:0] d0;
    logic v0;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    if (conv_start) starts.push_back(conv_temp ? TSLOT : int'(conv_chan));
    ovalid.push_back(out_valid); ochan.push_back(out_chan);
    otemp.push_back(out_temp); odata.push_back(out_data);
    d0 = out_data; v0 = out_valid;
    repeat (7) @(negedge clk);
    cs_n = 1'b1;
    repeat (7) @(negedge clk);
    chk(out_data == d0 && out_valid == v0, "R9", "hold across frame", out_data, d0);
  endtask

  task automatic expect_starts(string req, int exp[]);
    chk(starts.size() == exp.size(), req, "start count", starts.size(), exp.size());
    foreach (exp[i])
      if (i < starts.size()) chk(starts[i] == exp[i], req, "start slot", starts[i], exp[i]);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (5) @(negedge clk);
    chk(!conv_start && !out_valid && out_data == 0 && out_chan == 0 && !out_temp && !conv_temp,
        "R1", "outputs in reset", {out_valid, out_data}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!conv_start && !out_valid && out_data == 0 && conv_chan == 0,
        "R1", "outputs after reset", {out_valid, out_data}, 0);

    // R3: ascending walk with wrap over channels 1,2,5,7
    write_cfg(8'hA6, 1'b0);
    repeat (6) frame();
    expect_starts("R3", '{1, 2, 5, 7, 1, 2});
    chk(ovalid[0] == 0, "R6", "first frame invalid", ovalid[0], 0);
    chk(ovalid[2] == 1 && ochan[2] == 2, "R6", "latency tag", ochan[2], 2);
    chk(ochan[4] == 7, "R6", "latency tag", ochan[4], 7);

    // R4: new mask restarts at lowest
    write_cfg(8'h18, 1'b0);
    repeat (3) frame();
    expect_starts("R4", '{3, 4, 3});
    chk(ochan[0] == 2 && ovalid[0] == 1, "R6", "result spans write", ochan[0], 2);

    // R3 and R8: temperature slot after highest channel
    write_cfg(8'h81, 1'b1);
    repeat (4) frame();
    expect_starts("R3", '{0, 7, TSLOT, 0});
    chk(otemp[3] == 1 && ochan[3] == 0 && ovalid[3] == 1, "R8", "temp tag", otemp[3], 1);
    chk(odata[3][11] == 1, "R8", "twos complement sign kept", odata[3], 12'hE00);
    chk(otemp[2] == 0 && ochan[2] == 7, "R8", "channel straight", ochan[2], 7);

    // R5 and R7: empty selection and stray done
    write_cfg(8'h00, 1'b0);
    frame();
    frame();
    @(negedge clk);
    stray_req = 1;
    repeat (3) @(negedge clk);
    frame();
    expect_starts("R5", '{});
    chk(ovalid[0] == 1 && ochan[0] == 0, "R5", "last result still shown", ochan[0], 0);
    chk(ovalid[1] == 0 && odata[1] == 0, "R5", "invalid after empty", ovalid[1], 0);
    chk(ovalid[2] == 0 && odata[2] == 0, "R7", "stray done ignored", odata[2], 0);

    // R7: missing completion
    write_cfg(8'h01, 1'b0);
    frame();
    drop_next = 1;
    frame();
    frame();
    frame();
    expect_starts("R4", '{0, 0, 0, 0});
    chk(ovalid[1] == 1, "R7", "completed result valid", ovalid[1], 1);
    chk(ovalid[2] == 0 && odata[2] == 0, "R7", "missing done invalid", ovalid[2], 0);
    chk(ovalid[3] == 1, "R7", "recovery", ovalid[3], 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule